// File: doc/BRIEF.md
# Video Sync Edge and Field Detector

This block sits behind the sync pins of one video input port and turns the raw horizontal, vertical and frame-sync levels into clean internal timing events. It produces a one-clock line strobe and a one-clock field strobe. It also produces a field-identity level, where 1 means an odd field and 0 means an even field. A separate interrupt pulse is raised on a selectable edge of that field identity. All three sync inputs are treated as asynchronous. Each one passes through a multi-flop synchronizer before edge detection.

A 3-bit mode field selects the detection method. It chooses which vertical edge marks a field and how the field identity is formed. The identity can be sampled from HS directly, kept as a toggle that is resynchronised against HS, or kept as a free toggle. A separate mode takes both edges of a frame-sync input. The last mode hands line, field and identity over to strobe and identity inputs fed by an external timing-code decoder.

When the port drives its syncs out, two polarity bits pass the generated HS and VS straight through or inverted. Tristate control of the pins belongs elsewhere.

Top module: `field_sync_detector`

## Requirements
- R1: In modes 000 to 110, `line_stb` is high for exactly one clock, 3 clocks after `hs_in` goes from 0 to 1. A falling `hs_in` produces no strobe.
- R2: `field_stb` is high for exactly one clock, 3 clocks after the selected vertical edge of `vs_in`. The rising edge is selected in modes 000, 010 and 100. The falling edge is selected in modes 001, 011 and 101. The other `vs_in` edge produces no field strobe.
- R3: In mode 110, `field_stb` pulses 3 clocks after each rising and each falling edge of `fs_in`. `fid` follows the `fs_in` level with the same 3-clock delay. `vs_in` edges are ignored.
- R4: In modes 000 and 001, `fid` takes the level of `hs_in` present at the selected `vs_in` edge. It updates in the same cycle as `field_stb`.
- R5: In modes 010 and 011, `fid` inverts at every field strobe. At each falling `vs_in` edge, the `hs_in` level is compared with the current identity. The first mismatch is tolerated. A second mismatch in a row reloads `fid` from `hs_in`.
- R6: In modes 100 and 101, `fid` inverts at every field strobe, whatever the level of `hs_in`.
- R7: `irq_sel` bit 0 enables an interrupt on a 0-to-1 change of `fid`. Bit 1 enables one on a 1-to-0 change. Encoding 00 disables interrupts and 11 enables both edges. `irq` is a one-clock pulse in the cycle after `fid` changes.
- R8: `hs_out` equals `hs_gen` when `hs_inv` is 0 and its inverse when `hs_inv` is 1. `vs_out` relates to `vs_gen` and `vs_inv` in the same way. Both paths are combinational.
- R9: In mode 111, `line_stb`, `field_stb` and `fid` are the registered values of `ext_line_stb`, `ext_field_stb` and `ext_fid`, one clock later. Edges on `hs_in` produce no line strobe in this mode.
- R10: Synchronous active-high `rst` clears `fid` and holds all strobes and `irq` low. After release, sync levels that were already high produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Raw horizontal sync level (asynchronous) |
| vs_in | input | 1 | Raw vertical sync level (asynchronous) |
| fs_in | input | 1 | Raw frame-sync level (asynchronous) |
| mode | input | 3 | Detection mode select |
| hs_inv | input | 1 | Invert driven horizontal sync |
| vs_inv | input | 1 | Invert driven vertical sync |
| irq_sel | input | 2 | Field-identity interrupt edge select |
| ext_line_stb | input | 1 | Line strobe from external timing-code decoder |
| ext_field_stb | input | 1 | Field strobe from external timing-code decoder |
| ext_fid | input | 1 | Field identity from external timing-code decoder |
| hs_gen | input | 1 | Generated horizontal sync to drive out |
| vs_gen | input | 1 | Generated vertical sync to drive out |
| hs_out | output | 1 | Horizontal sync after polarity selection |
| vs_out | output | 1 | Vertical sync after polarity selection |
| line_stb | output | 1 | One-clock line start strobe |
| field_stb | output | 1 | One-clock field start strobe |
| fid | output | 1 | Field identity (1 odd, 0 even) |
| irq | output | 1 | One-clock field-identity interrupt |

## Verification
An edge on a pin-side sync input first crosses two synchronizer flops and then one strobe register. Its strobe is therefore due at the third clock after the change, and the field identity moves in that same cycle. The interrupt follows one clock later. The external-decoder path has a single register, and the polarity outputs are combinational. The bench changes inputs on the falling clock edge and counts falling edges to the expected cycle. It checks that a strobe is still low one cycle early, high in its own cycle and low again one cycle later, so both a wrong latency and a stretched pulse are caught.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SYNC_W = 3;
    localparam int IRQ_ON_RISE = 0;
    localparam int IRQ_ON_FALL = 1;

    typedef enum logic [2:0] {
        MODE_VR_DIRECT = 3'b000,
        MODE_VF_DIRECT = 3'b001,
        MODE_VR_FORCED = 3'b010,
        MODE_VF_FORCED = 3'b011,
        MODE_VR_FREE   = 3'b100,
        MODE_VF_FREE   = 3'b101,
        MODE_FRAME     = 3'b110,
        MODE_EXT       = 3'b111
    } sync_mode_e;

    typedef enum logic [1:0] {
        FID_DIRECT,
        FID_FORCED,
        FID_FREE,
        FID_FRAME
    } fid_src_e;

    // Bit order of the synchronised sync bus: hs in MSB, fs in LSB.
    typedef struct packed {
        logic hs;
        logic vs;
        logic fs;
    } sync_lvl_t;

    typedef struct packed {
        logic vs_rise;
        logic vs_fall;
        logic fs_rise;
        logic fs_fall;
    } vedge_t;

    typedef struct packed {
        logic     ext;
        logic     v_rise;
        logic     v_fall;
        fid_src_e src;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t cfg;
        cfg.ext    = (m == MODE_EXT);
        cfg.v_rise = (m[2:1] != 2'b11) && !m[0];
        cfg.v_fall = (m[2:1] != 2'b11) &&  m[0];
        unique case (m[2:1])
            2'b00:   cfg.src = FID_DIRECT;
            2'b01:   cfg.src = FID_FORCED;
            2'b10:   cfg.src = FID_FREE;
            default: cfg.src = FID_FRAME;
        endcase
        return cfg;
    endfunction

    function automatic logic is_free_mode(input logic [2:0] m);
        return m[2:1] == 2'b10;
    endfunction
endpackage

// File: rtl/fsd_sync.sv
module fsd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/fsd_edge.sv
module fsd_edge #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign rise[b] = armed &  cur[b] & ~prev[b];
            assign fall[b] = armed & ~cur[b] &  prev[b];
        end
    endgenerate
endmodule

// File: rtl/fsd_field.sv
module fsd_field
    import fsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      armed,
    input  mode_cfg_t cfg,
    input  logic      hs_lvl,
    input  logic      fs_lvl,
    input  vedge_t    edges,
    input  logic      ext_field,
    input  logic      ext_fid,
    output logic      field_evt,
    output logic      fid
);
    timeunit 1ns;
    timeprecision 100ps;

    logic miss_q, miss_n;
    logic fid_n;
    logic expect_fid;

    always_comb begin
        if (cfg.ext) begin
            field_evt = armed & ext_field;
        end else if (cfg.src == FID_FRAME) begin
            field_evt = edges.fs_rise | edges.fs_fall;
        end else begin
            field_evt = (cfg.v_rise & edges.vs_rise) | (cfg.v_fall & edges.vs_fall);
        end
    end

    assign expect_fid = field_evt ? ~fid : fid;

    always_comb begin
        fid_n  = fid;
        miss_n = miss_q;
        if (!armed) begin
            fid_n  = fid;
            miss_n = 1'b0;
        end else if (cfg.ext) begin
            fid_n = ext_fid;
        end else begin
            unique case (cfg.src)
                FID_DIRECT: if (field_evt) fid_n = hs_lvl;
                FID_FREE:   if (field_evt) fid_n = ~fid;
                FID_FRAME:  fid_n = fs_lvl;
                FID_FORCED: begin
                    fid_n = expect_fid;
                    if (edges.vs_fall) begin
                        if (hs_lvl != expect_fid) begin
                            if (miss_q) begin
                                fid_n  = hs_lvl;
                                miss_n = 1'b0;
                            end else begin
                                miss_n = 1'b1;
                            end
                        end else begin
                            miss_n = 1'b0;
                        end
                    end
                end
                default: fid_n = fid;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fid    <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            fid    <= fid_n;
            miss_q <= miss_n;
        end
    end
endmodule

// File: rtl/fsd_irq.sv
module fsd_irq
    import fsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fid,
    input  logic [1:0] sel,
    output logic       irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic fid_q;
    logic hit;

    assign hit = (sel[IRQ_ON_RISE] &  fid & ~fid_q)
               | (sel[IRQ_ON_FALL] & ~fid &  fid_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            fid_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            fid_q <= fid;
            irq   <= hit;
        end
    end
endmodule

// File: rtl/field_sync_detector.sv
module field_sync_detector
    import fsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_in,
    input  logic       vs_in,
    input  logic       fs_in,
    input  logic [2:0] mode,
    input  logic       hs_inv,
    input  logic       vs_inv,
    input  logic [1:0] irq_sel,
    input  logic       ext_line_stb,
    input  logic       ext_field_stb,
    input  logic       ext_fid,
    input  logic       hs_gen,
    input  logic       vs_gen,
    output logic       hs_out,
    output logic       vs_out,
    output logic       line_stb,
    output logic       field_stb,
    output logic       fid,
    output logic       irq
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ARM_CYC = SYNC_STAGES + 1;
    localparam int ARM_W   = $clog2(ARM_CYC + 1);

    mode_cfg_t         cfg;
    sync_lvl_t         raw_lvl;
    sync_lvl_t         lvl;
    sync_lvl_t         rise_s;
    sync_lvl_t         fall_s;
    logic [SYNC_W-1:0] sync_q;
    logic [SYNC_W-1:0] rise_v;
    logic [SYNC_W-1:0] fall_v;
    vedge_t            vedges;
    logic [ARM_W-1:0]  arm_cnt;
    logic              armed;
    logic              field_evt;
    logic              line_evt;
    logic              unused_hs_fall;

    assign cfg = decode_mode(mode);

    // Start-up window: edges count only after the synchronizer and the
    // previous-sample register hold real input values.
    always_ff @(posedge clk) begin
        if (rst)                        arm_cnt <= '0;
        else if (arm_cnt != ARM_W'(ARM_CYC)) arm_cnt <= arm_cnt + 1'b1;
    end
    assign armed = (arm_cnt == ARM_W'(ARM_CYC));

    assign raw_lvl = '{hs: hs_in, vs: vs_in, fs: fs_in};

    fsd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (sync_q)
    );
    assign lvl = sync_lvl_t'(sync_q);

    fsd_edge #(.WIDTH(SYNC_W)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .armed (armed),
        .cur   (sync_q),
        .rise  (rise_v),
        .fall  (fall_v)
    );
    assign rise_s = sync_lvl_t'(rise_v);
    assign fall_s = sync_lvl_t'(fall_v);
    assign unused_hs_fall = fall_s.hs;

    assign vedges = '{vs_rise: rise_s.vs, vs_fall: fall_s.vs,
                      fs_rise: rise_s.fs, fs_fall: fall_s.fs};

    fsd_field u_field (
        .clk       (clk),
        .rst       (rst),
        .armed     (armed),
        .cfg       (cfg),
        .hs_lvl    (lvl.hs),
        .fs_lvl    (lvl.fs),
        .edges     (vedges),
        .ext_field (ext_field_stb),
        .ext_fid   (ext_fid),
        .field_evt (field_evt),
        .fid       (fid)
    );

    assign line_evt = cfg.ext ? (armed & ext_line_stb) : rise_s.hs;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_stb  <= 1'b0;
            field_stb <= 1'b0;
        end else begin
            line_stb  <= line_evt;
            field_stb <= field_evt;
        end
    end

    fsd_irq u_irq (
        .clk (clk),
        .rst (rst),
        .fid (fid),
        .sel (irq_sel),
        .irq (irq)
    );

    assign hs_out = hs_inv ? ~hs_gen : hs_gen;
    assign vs_out = vs_inv ? ~vs_gen : vs_gen;
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker
    import fsd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic [1:0] irq_sel,
    input logic       fs_in,
    input logic       line_stb,
    input logic       field_stb,
    input logic       fid,
    input logic       irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    // R1
    line_single_chk: assert property (@(posedge clk) disable iff (rst)
        (line_stb && mode != MODE_EXT) |=> (mode == MODE_EXT || !line_stb));

    // R2
    field_single_chk: assert property (@(posedge clk) disable iff (rst)
        (field_stb && mode != MODE_EXT) |=> (mode == MODE_EXT || !field_stb));

    // R3
    frame_fid_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd6 && mode == MODE_FRAME && $past(mode) == MODE_FRAME
         && $past(mode, 2) == MODE_FRAME && $past(mode, 3) == MODE_FRAME)
        |-> fid == $past(fs_in, 3));

    // R6
    free_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (field_stb && is_free_mode($past(mode))) |-> fid != $past(fid));

    // R7
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 2'b00 && $past(irq_sel) == 2'b00) |-> !irq);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!line_stb && !field_stb && !irq && !fid));
endmodule

bind field_sync_detector fsd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .irq_sel   (irq_sel),
    .fs_in     (fs_in),
    .line_stb  (line_stb),
    .field_stb (field_stb),
    .fid       (fid),
    .irq       (irq)
);

// File: tb/field_sync_detector_bench.sv
module field_sync_detector_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs_in = 1'b0, vs_in = 1'b0, fs_in = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       hs_inv = 1'b0, vs_inv = 1'b0;
    logic [1:0] irq_sel = 2'b00;
    logic       ext_line_stb = 1'b0, ext_field_stb = 1'b0, ext_fid = 1'b0;
    logic       hs_gen = 1'b0, vs_gen = 1'b0;
    logic       hs_out, vs_out, line_stb, field_stb, fid, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    field_sync_detector u_field_sync_detector (
        .clk(clk), .rst(rst), .hs_in(hs_in), .vs_in(vs_in), .fs_in(fs_in),
        .mode(mode), .hs_inv(hs_inv), .vs_inv(vs_inv), .irq_sel(irq_sel),
        .ext_line_stb(ext_line_stb), .ext_field_stb(ext_field_stb),
        .ext_fid(ext_fid), .hs_gen(hs_gen), .vs_gen(vs_gen),
        .hs_out(hs_out), .vs_out(vs_out), .line_stb(line_stb),
        .field_stb(field_stb), .fid(fid), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic pick(input int w);
        case (w)
            0:       return line_stb;
            1:       return field_stb;
            default: return irq;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after driving at a falling edge: low one cycle early,
    // high at lat, low again one cycle later.
    task automatic pulse_at(input string req, input int w, input int lat, input logic exp);
        tick(lat - 1);
        chk({req, " early"}, pick(w), 1'b0);
        tick(1);
        chk({req, " due"}, pick(w), exp);
        tick(1);
        chk({req, " after"}, pick(w), 1'b0);
    endtask

    task automatic quiet(input string req, input int w, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            seen |= pick(w);
        end
        chk(req, seen, 1'b0);
    endtask

    task automatic apply_reset(input logic [2:0] m);
        @(negedge clk);
        rst = 1'b1; mode = m;
        hs_in = 0; vs_in = 0; fs_in = 0;
        ext_line_stb = 0; ext_field_stb = 0; ext_fid = 0;
        tick(3);
        rst = 1'b0;
        tick(6);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; mode = 3'b000; hs_in = 1; vs_in = 1; fs_in = 1;
        tick(4);
        chk("R10 fid in reset", fid, 1'b0);
        chk("R10 line in reset", line_stb, 1'b0);
        chk("R10 field in reset", field_stb, 1'b0);
        chk("R10 irq in reset", irq, 1'b0);
        rst = 1'b0;
        quiet("R10 no line after release with high HS", 0, 10);
        chk("R10 no field after release", field_stb, 1'b0);
    endtask

    task automatic t_line(input logic [2:0] m);
        apply_reset(m);
        hs_in = 1;
        pulse_at("R1 line on HS rise", 0, 3, 1'b1);
        tick(2);
        hs_in = 0;
        quiet("R1 no line on HS fall", 0, 6);
    endtask

    task automatic t_direct();
        apply_reset(3'b000);
        hs_in = 1; tick(5);
        vs_in = 1;
        pulse_at("R2 field on VS rise mode000", 1, 3, 1'b1);
        chk("R4 fid=HS 1 mode000", fid, 1'b1);
        vs_in = 0;
        quiet("R2 no field on VS fall mode000", 1, 6);
        hs_in = 0; tick(5);
        vs_in = 1;
        pulse_at("R2 field mode000 second", 1, 3, 1'b1);
        chk("R4 fid=HS 0 mode000", fid, 1'b0);

        apply_reset(3'b001);
        hs_in = 1; tick(5);
        vs_in = 1;
        quiet("R2 no field on VS rise mode001", 1, 6);
        vs_in = 0;
        pulse_at("R2 field on VS fall mode001", 1, 3, 1'b1);
        chk("R4 fid=HS 1 mode001", fid, 1'b1);
        hs_in = 0; vs_in = 1; tick(5);
        vs_in = 0;
        pulse_at("R2 field mode001 second", 1, 3, 1'b1);
        chk("R4 fid=HS 0 mode001", fid, 1'b0);
    endtask

    task automatic t_free();
        logic e = 1'b0;
        apply_reset(3'b100);
        for (int i = 0; i < 4; i++) begin
            hs_in = i[0]; tick(4);
            vs_in = 1;
            pulse_at("R6 field mode100", 1, 3, 1'b1);
            e = ~e;
            chk("R6 free toggle mode100", fid, e);
            vs_in = 0; tick(4);
        end
        apply_reset(3'b101);
        hs_in = 0; vs_in = 1; tick(5);
        vs_in = 0;
        pulse_at("R6 field mode101", 1, 3, 1'b1);
        chk("R6 free toggle mode101 ignores HS=0", fid, 1'b1);
    endtask

    task automatic t_forced();
        logic [4:0] hs_seq  = 5'b01001; // applied LSB first: 1,0,0,1,0
        logic [4:0] fid_exp = 5'b01101; // expected LSB first: 1,0,1,1,0
        apply_reset(3'b011);
        for (int i = 0; i < 5; i++) begin
            hs_in = hs_seq[i]; tick(4);
            vs_in = 1; tick(4);
            vs_in = 0;
            pulse_at("R5 field mode011", 1, 3, 1'b1);
            chk("R5 forced toggle fid", fid, fid_exp[i]);
        end
        apply_reset(3'b010);
        hs_in = 1; tick(4);
        vs_in = 1;
        pulse_at("R2 field on VS rise mode010", 1, 3, 1'b1);
        chk("R5 toggle at rise mode010", fid, 1'b1);
        vs_in = 0;
        quiet("R2 no field on VS fall mode010", 1, 6);
        chk("R5 agreeing HS keeps fid mode010", fid, 1'b1);
    endtask

    task automatic t_frame();
        apply_reset(3'b110);
        fs_in = 1;
        pulse_at("R3 field on FS rise", 1, 3, 1'b1);
        chk("R3 fid follows FS high", fid, 1'b1);
        tick(3);
        fs_in = 0;
        pulse_at("R3 field on FS fall", 1, 3, 1'b1);
        chk("R3 fid follows FS low", fid, 1'b0);
        vs_in = 1;
        quiet("R3 VS ignored mode110", 1, 6);
    endtask

    task automatic t_irq();
        for (int s = 0; s < 4; s++) begin
            logic [1:0] sv = 2'(s);
            apply_reset(3'b110);
            irq_sel = sv;
            tick(2);
            fs_in = 1;
            pulse_at("R7 irq on fid rise", 2, 4, sv[0]);
            tick(3);
            fs_in = 0;
            pulse_at("R7 irq on fid fall", 2, 4, sv[1]);
        end
        irq_sel = 2'b00;
    endtask

    task automatic t_pol();
        for (int k = 0; k < 16; k++) begin
            logic [3:0] kv = 4'(k);
            @(negedge clk);
            hs_gen = kv[0]; vs_gen = kv[1]; hs_inv = kv[2]; vs_inv = kv[3];
            #1;
            chk("R8 hs_out polarity", hs_out, kv[2] ? ~kv[0] : kv[0]);
            chk("R8 vs_out polarity", vs_out, kv[3] ? ~kv[1] : kv[1]);
        end
    endtask

    task automatic t_ext();
        apply_reset(3'b111);
        ext_line_stb = 1;
        tick(1);
        chk("R9 ext line due", line_stb, 1'b1);
        ext_line_stb = 0;
        tick(1);
        chk("R9 ext line after", line_stb, 1'b0);
        ext_field_stb = 1;
        tick(1);
        chk("R9 ext field due", field_stb, 1'b1);
        ext_field_stb = 0;
        tick(1);
        chk("R9 ext field after", field_stb, 1'b0);
        ext_fid = 1;
        tick(1);
        chk("R9 ext fid high", fid, 1'b1);
        ext_fid = 0;
        tick(1);
        chk("R9 ext fid low", fid, 1'b0);
        hs_in = 1;
        quiet("R9 HS ignored in mode111", 0, 6);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_line(3'b000);
        t_line(3'b101);
        t_direct();
        t_free();
        t_forced();
        t_frame();
        t_irq();
        t_pol();
        t_ext();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule